// File: doc/BRIEF.md
# Shared-Memory Fetch/Data Arbiter

This block lets a five-stage in-order pipeline work with a single memory that holds both instructions and data. In every cycle it may receive an instruction fetch request from the fetch stage and a load or a store from the memory-access stage. Only one of them can use the memory port. A data access always wins, so the program keeps making progress. The block then raises a stall. The stall holds the program counter and the fetch/decode register and puts a zero-control bubble into the decode/execute register. Instructions already past decode keep moving.

The memory is a synchronous, word-addressed array. It has one address, one write-data bus and one write enable, and read data appears one cycle after the request. Each read response carries a tag that says whether it answers a fetch or a load. The fetch stage and the memory-access stage therefore see only their own responses. The conflict cannot be removed by padding the program with no-op instructions, because those no-ops must also be fetched through the same port. The hardware must resolve it. Back-to-back memory instructions stall fetch in every cycle, with no limit. Fetch resumes in the first cycle that has no data access.

Top module: `shared_mem_arbiter`

## Requirements
- R1: After reset, `fetch_stall`, `if_rvalid` and `ld_rvalid` are low, and every memory word reads as zero.
- R2: `fetch_stall` is high in a cycle exactly when `if_req` is high and a load (`mem_rd`) or a store (`mem_wr`) is presented in that same cycle. It is low otherwise.
- R3: A load presented in cycle t uses the port whatever `if_req` is. `ld_rvalid` is high in cycle t+1, with `ld_rdata` equal to the word at `mem_addr`.
- R4: A store presented in cycle t writes `mem_wdata` to `mem_addr` at the end of cycle t, whatever `if_req` is. A read of that word from cycle t+1 on returns the new value. A store produces no read response in cycle t+1.
- R5: A fetch with no data access in cycle t gives `if_rvalid` high in cycle t+1, with `if_rdata` equal to the word at `if_addr`.
- R6: Responses are tagged. A stalled fetch gives no fetch response. `if_rvalid` and `ld_rvalid` are never high together, and a load never raises `if_rvalid`.
- R7: Consecutive data accesses keep `fetch_stall` high in every one of those cycles, with no starvation limit. The first cycle without a data access grants the fetch.
- R8: A pipeline that runs store, load, branch, add, set-less-than against this block finishes in 11 cycles. The fetch stalls in cycles 4 and 5.
- R9: A cycle with no request of either kind gives no response in the next cycle.
- R10: `mem_rd` and `mem_wr` are never high in the same cycle. This is an input rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| if_req | input | 1 | Fetch stage wants an instruction word |
| if_addr | input | AW | Word address of the fetch |
| mem_rd | input | 1 | Memory-access stage holds a load |
| mem_wr | input | 1 | Memory-access stage holds a store |
| mem_addr | input | AW | Word address of the load or store |
| mem_wdata | input | DW | Store data |
| fetch_stall | output | 1 | Hold PC and fetch/decode, insert a bubble into decode/execute |
| if_rvalid | output | 1 | Fetch response valid |
| if_rdata | output | DW | Fetched instruction word |
| ld_rvalid | output | 1 | Load response valid |
| ld_rdata | output | DW | Loaded data word |

## Verification
The stall is combinational, so it is sampled in the same cycle as the request, shortly after the inputs change. Read responses pass through one register. They are checked in the following cycle, before the next rising edge, against expectations the bench recorded when it drove the request. A store's effect is checked by a later load or fetch of the same word, from the next cycle on. The pipeline sequence counts cycles from the first fetch until the last instruction reaches write-back, and records the cycle numbers in which the stall was seen.

// File: rtl/arb_pkg.sv
// Package: shared types for the fetch/data arbiter.
// Assumes: one response is outstanding per cycle at most.
package arb_pkg;
    // Owner of the word that the memory returns in the next cycle
    typedef enum logic [1:0] {
        TAG_NONE  = 2'd0,
        TAG_FETCH = 2'd1,
        TAG_LOAD  = 2'd2
    } resp_tag_e;
endpackage

// File: rtl/port_arbiter.sv
// Module: port_arbiter
// Picks the owner of the single memory port for this cycle. A data access
// always wins. A fetch that loses raises the stall.
// Assumes: load and store are never requested together.
module port_arbiter
    import arb_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic          if_req,
    input  logic [AW-1:0] if_addr,
    input  logic          ld_req,
    input  logic          st_req,
    input  logic [AW-1:0] dat_addr,
    input  logic [DW-1:0] dat_wdata,
    output logic          stall,
    output logic          port_en,
    output logic          port_we,
    output logic [AW-1:0] port_addr,
    output logic [DW-1:0] port_wdata,
    output resp_tag_e     issue_tag
);
    logic data_acc;

    // Grant decision and port multiplexing
    always_comb begin
        data_acc   = ld_req | st_req;
        stall      = if_req & data_acc;
        port_en    = data_acc | if_req;
        port_we    = st_req;
        port_wdata = dat_wdata;
        port_addr  = if_addr;
        issue_tag  = TAG_NONE;
        if (data_acc) begin
            port_addr = dat_addr;
            issue_tag = ld_req ? TAG_LOAD : TAG_NONE;
        end else if (if_req) begin
            issue_tag = TAG_FETCH;
        end
    end
endmodule

// File: rtl/sync_word_mem.sv
// Module: sync_word_mem
// Word-addressed single-port memory. A write lands at the clock edge.
// Read data is registered and is valid one cycle after the request.
// Assumes: DEPTH is small enough to clear on reset.
module sync_word_mem #(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store_q [DEPTH];

    // Array storage, cleared on reset, with a write on enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) store_q[i] <= '0;
        end else if (en && we) begin
            store_q[addr] <= wdata;
        end
    end

    // Registered read port
    always_ff @(posedge clk) begin
        if (!rst_n)          rdata <= '0;
        else if (en && !we)  rdata <= store_q[addr];
    end
endmodule

// File: rtl/resp_router.sv
// Module: resp_router
// Delays the issue tag by one cycle to line up with the memory read data,
// then hands the word only to the stage that asked for it.
// Assumes: the memory has one cycle of read latency.
module resp_router
    import arb_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  resp_tag_e     issue_tag,
    input  logic [DW-1:0] mem_rdata,
    output logic          if_rvalid,
    output logic [DW-1:0] if_rdata,
    output logic          ld_rvalid,
    output logic [DW-1:0] ld_rdata
);
    resp_tag_e tag_q;

    // Tag pipeline register
    always_ff @(posedge clk) begin
        if (!rst_n) tag_q <= TAG_NONE;
        else        tag_q <= issue_tag;
    end

    // Route the word to its owner and zero it elsewhere
    always_comb begin
        if_rvalid = (tag_q == TAG_FETCH);
        ld_rvalid = (tag_q == TAG_LOAD);
        if_rdata  = if_rvalid ? mem_rdata : '0;
        ld_rdata  = ld_rvalid ? mem_rdata : '0;
    end

    // R6
    tag_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tag_q != resp_tag_e'(2'd3));
endmodule

// File: rtl/shared_mem_arbiter.sv
// Module: shared_mem_arbiter (top)
// Shares one memory between instruction fetch and data access. Data wins,
// the fetch stalls, and read data is returned tagged to its requester.
// Assumes: mem_rd and mem_wr are exclusive.
module shared_mem_arbiter
    import arb_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          if_req,
    input  logic [AW-1:0] if_addr,
    input  logic          mem_rd,
    input  logic          mem_wr,
    input  logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_wdata,
    output logic          fetch_stall,
    output logic          if_rvalid,
    output logic [DW-1:0] if_rdata,
    output logic          ld_rvalid,
    output logic [DW-1:0] ld_rdata
);
    logic          port_en;
    logic          port_we;
    logic [AW-1:0] port_addr;
    logic [DW-1:0] port_wdata;
    logic [DW-1:0] port_rdata;
    resp_tag_e     issue_tag;

    port_arbiter #(.AW(AW), .DW(DW)) u_arb (
        .if_req     (if_req),
        .if_addr    (if_addr),
        .ld_req     (mem_rd),
        .st_req     (mem_wr),
        .dat_addr   (mem_addr),
        .dat_wdata  (mem_wdata),
        .stall      (fetch_stall),
        .port_en    (port_en),
        .port_we    (port_we),
        .port_addr  (port_addr),
        .port_wdata (port_wdata),
        .issue_tag  (issue_tag)
    );

    sync_word_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (port_en),
        .we    (port_we),
        .addr  (port_addr),
        .wdata (port_wdata),
        .rdata (port_rdata)
    );

    resp_router #(.DW(DW)) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue_tag (issue_tag),
        .mem_rdata (port_rdata),
        .if_rvalid (if_rvalid),
        .if_rdata  (if_rdata),
        .ld_rvalid (ld_rvalid),
        .ld_rdata  (ld_rdata)
    );

    // R10
    excl_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R3
    load_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> ld_rvalid);

    // R4
    store_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (!ld_rvalid && !if_rvalid));

    // R5
    fetch_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (if_req && !mem_rd && !mem_wr) |=> if_rvalid);

    // R6
    stalled_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall |=> !if_rvalid);

    // R6
    one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({if_rvalid, ld_rvalid}));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!if_req && !mem_rd && !mem_wr) |=> (!if_rvalid && !ld_rvalid));
endmodule

// File: tb/tb_shared_mem_arbiter.sv
module tb_shared_mem_arbiter;
    localparam int AW = 6;
    localparam int DW = 32;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          if_req = 1'b0;
    logic [AW-1:0] if_addr = '0;
    logic          mem_rd = 1'b0;
    logic          mem_wr = 1'b0;
    logic [AW-1:0] mem_addr = '0;
    logic [DW-1:0] mem_wdata = '0;
    logic          fetch_stall;
    logic          if_rvalid;
    logic [DW-1:0] if_rdata;
    logic          ld_rvalid;
    logic [DW-1:0] ld_rdata;

    shared_mem_arbiter #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .if_req(if_req), .if_addr(if_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .fetch_stall(fetch_stall),
        .if_rvalid(if_rvalid), .if_rdata(if_rdata),
        .ld_rvalid(ld_rvalid), .ld_rdata(ld_rdata)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    logic [DW-1:0] shadow [DEPTH];
    logic          p_if = 1'b0, p_ld = 1'b0;
    logic [DW-1:0] p_ifd = '0, p_ldd = '0;
    logic          last_stall = 1'b0;
    string         p_tag = "R5";
    int            cyc = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic exp_stall(input logic f, input logic r, input logic w);
        return f && (r || w);
    endfunction

    // One cycle: check last cycle's responses, drive new inputs, check stall
    task automatic step(input logic f, input logic [AW-1:0] fa, input logic r,
                        input logic w, input logic [AW-1:0] da, input logic [DW-1:0] wd,
                        input string tag);
        @(negedge clk);
        check("R6 if_rvalid", {31'd0, if_rvalid}, {31'd0, p_if});
        check("R6 ld_rvalid", {31'd0, ld_rvalid}, {31'd0, p_ld});
        if (p_if) check({p_tag, " if_rdata"}, if_rdata, p_ifd);
        if (p_ld) check({p_tag, " ld_rdata"}, ld_rdata, p_ldd);
        if_req = f; if_addr = fa; mem_rd = r; mem_wr = w;
        mem_addr = da; mem_wdata = wd;
        #1;
        last_stall = fetch_stall;
        check({tag, " stall"}, {31'd0, fetch_stall}, {31'd0, exp_stall(f, r, w)});
        p_if  = f && !r && !w;
        p_ifd = shadow[fa];
        p_ld  = r;
        p_ldd = shadow[da];
        p_tag = tag;
        if (w) shadow[da] = wd;
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) shadow[i] = '0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state of the outputs
        check("R1 stall", {31'd0, fetch_stall}, 32'd0);
        check("R1 if_rvalid", {31'd0, if_rvalid}, 32'd0);
        check("R1 ld_rvalid", {31'd0, ld_rvalid}, 32'd0);
        // R1 every word reads zero after reset
        for (int i = 0; i < DEPTH; i++) step(1'b1, AW'(i), 1'b0, 1'b0, '0, '0, "R1");

        // R4 store, then read back by load and by fetch
        step(1'b1, 6'd2, 1'b0, 1'b1, 6'd9, 32'hCAFE_0009, "R4");
        step(1'b0, 6'd0, 1'b1, 1'b0, 6'd9, '0, "R4");
        step(1'b1, 6'd9, 1'b0, 1'b0, 6'd0, '0, "R4");
        // R3 load wins against fetch
        step(1'b1, 6'd1, 1'b1, 1'b0, 6'd9, '0, "R3");
        // R9 idle cycle
        step(1'b0, 6'd0, 1'b0, 1'b0, 6'd0, '0, "R9");
        // R7 four data accesses in a row, fetch waiting throughout
        step(1'b1, 6'd5, 1'b1, 1'b0, 6'd9, '0, "R7");
        step(1'b1, 6'd5, 1'b0, 1'b1, 6'd5, 32'h1234_5678, "R7");
        step(1'b1, 6'd5, 1'b1, 1'b0, 6'd5, '0, "R7");
        step(1'b1, 6'd5, 1'b0, 1'b1, 6'd6, 32'h0000_00A6, "R7");
        step(1'b1, 6'd5, 1'b0, 1'b0, 6'd0, '0, "R7");
        step(1'b0, 6'd0, 1'b0, 1'b0, 6'd0, '0, "R9");

        // Random mix: R2 R3 R4 R5 R6 checked every cycle
        for (int n = 0; n < 3000; n++) begin
            int k;
            logic r, w;
            k = $urandom_range(0, 3);
            r = (k == 1);
            w = (k == 2);
            step(1'($urandom_range(0, 1)), AW'($urandom), r, w, AW'($urandom),
                 $urandom, "R2");
        end
        step(1'b0, 6'd0, 1'b0, 1'b0, 6'd0, '0, "R9");

        // R8 five-stage pipeline: store, load, branch, add, set-less-than
        begin
            int pc, id_i, ex_i, mem_i, wb_i, done_c, st_cnt;
            int stall_c [2];
            pc = 0; id_i = -1; ex_i = -1; mem_i = -1; wb_i = -1;
            done_c = 0; st_cnt = 0;
            stall_c[0] = 0; stall_c[1] = 0;
            for (int c = 1; c <= 30 && done_c == 0; c++) begin
                logic fr;
                fr = (pc < 5);
                step(fr, AW'(pc), mem_i == 1, mem_i == 0, 6'd3,
                     32'h0000_0016, "R8");
                if (last_stall) begin
                    if (st_cnt < 2) stall_c[st_cnt] = c;
                    st_cnt++;
                end
                if (wb_i == 4) done_c = c;
                wb_i  = mem_i;
                mem_i = ex_i;
                ex_i  = last_stall ? -1 : id_i;
                if (!last_stall) begin
                    id_i = fr ? pc : -1;
                    if (fr) pc++;
                end
            end
            check("R8 total cycles", 32'(done_c), 32'd11);
            check("R8 stall count", 32'(st_cnt), 32'd2);
            check("R8 first stall cycle", 32'(stall_c[0]), 32'd4);
            check("R8 second stall cycle", 32'(stall_c[1]), 32'd5);
        end
        step(1'b0, 6'd0, 1'b0, 1'b0, 6'd0, '0, "R9");
        step(1'b0, 6'd0, 1'b0, 1'b0, 6'd0, '0, "R9");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule